// File: doc/BRIEF.md
# System-Management Memory Visibility Router

This block decides, for every memory access, where that access is sent. It can go to DRAM, to the PCI / legacy-video path, or to a black hole. The decision uses the access address, a flag that marks the access as issued in system-management mode (SMM), and two control bytes. Software programs those bytes through a small configuration write port. The rules cover three regions:

- the 128 KB legacy window at 0xA0000;
- a 128 KB high alias of that window at 0xFEDA0000;
- a protected segment just below the top of low memory (TOLUD), whose size is selectable.

Addresses outside these regions follow the plain low-memory split.

Software can set a lock bit. Once it is set, the control bytes stay frozen until reset, and the bit that opens system-management memory to ordinary accesses is forced clear. Ordinary accesses that land in the protected segment read back all ones, and their writes are dropped. A 16-bit size register supports a query handshake: firmware writes the query code and reads back the configured size of the extended segment in megabytes.

Routing is combinational, from the registered control state. A configuration write therefore changes routing from the next cycle on. The parameter `EXT_MB` (default 16) must lie between 0 and 4095.

Top module: `smram_router`

## Requirements
- R1: After reset, select 0 reads 0x0002 and select 1 reads 0x0038. Select 2 reads 0xFFFF when `EXT_MB` is nonzero. Select 3 always reads 0.
- R2: The register selects are:
  - 0: the SMRAM control byte (open = bit 6, lock = bit 4, global enable = bit 3).
  - 1: the extended control byte (high enable = bit 7, size = bits 2:1, segment enable = bit 0).
  - 2: the 16-bit size register.

  While unlocked, only bits 6, 4 and 3 of byte 0 and bits 7, 2, 1 and 0 of byte 1 are writable. All other bits keep their reset values. A write is visible from the next cycle.
- R3: A write that sets the lock bit clears the open bit in the same update. While locked, writes to selects 0 and 1 change nothing until reset.
- R4: A non-SMM access to 0xA0000–0xBFFFF goes to DRAM only when open is set and high enable is clear. Otherwise it goes to PCI.
- R5: A non-SMM access to 0xFEDA0000–0xFEDBFFFF goes to DRAM only when open and high enable are both set. Otherwise it goes to PCI.
- R6: For an SMM access with global enable set:
  - the legacy window goes to DRAM when high enable is clear;
  - the high alias goes to DRAM when high enable is set.

  In every other SMM case the non-SMM rules of R4 and R5 apply.
- R7: The segment size is 0 when segment enable is clear. When it is set, size codes 00, 01, 10 and 11 give 1, 2, 8 and `EXT_MB` MB. The segment spans [TOLUD − size, TOLUD).
- R8: Inside the segment, an SMM access goes to DRAM (route 0). A non-SMM access goes to the hole (route 2), with `hole_rdata` all ones and `wr_drop` high on a write.
- R9: Outside the three regions, an address below TOLUD routes to DRAM (0) and any other address routes to PCI (1). `hole_rdata` and `wr_drop` are zero whenever the route is not the hole.
- R10: A write of 0xFFFF to select 2 loads `EXT_MB`. Any other value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 SMRAM byte, 1 extended byte, 2 size register) |
| cfg_wdata | input | 16 | Write data (bytes use bits 7:0) |
| cfg_rdata | output | 16 | Read data of the selected register |
| acc_addr | input | AW | Access address |
| acc_smm | input | 1 | Access issued in system-management mode |
| acc_wr | input | 1 | Access is a write |
| acc_route | output | 2 | 0 DRAM, 1 PCI, 2 hole |
| hole_rdata | output | DW | All ones for a hole access, else zero |
| wr_drop | output | 1 | Write absorbed by the hole |

## Verification
The state that is hardest to reach is the one after the lock bit is set. Every later write to the control bytes must then be absorbed, while routing keeps following the frozen values. The stimulus first sets open, global enable and high enable, and walks the legacy window and the high alias in both modes. It then sets lock and open in a single write, tries to reopen and to re-size the segment, and finally resets to show that the lock clears. The segment edges are probed one byte outside and one byte inside for every size code.

// File: rtl/smram_pkg.sv
// Shared definitions for the system-management memory router.
// Assumes byte-wide control registers and a 2-bit route code.
package smram_pkg;
    typedef enum logic [1:0] {
        RT_DRAM = 2'd0,
        RT_PCI  = 2'd1,
        RT_HOLE = 2'd2
    } route_e;

    // Bit positions in the SMRAM control byte
    localparam int SM_OPEN = 6;
    localparam int SM_LOCK = 4;
    localparam int SM_GEN  = 3;
    // Bit positions in the extended control byte
    localparam int ES_HEN  = 7;
    localparam int ES_SZHI = 2;
    localparam int ES_SZLO = 1;
    localparam int ES_TEN  = 0;

    localparam logic [7:0] SM_RST      = 8'h02;
    localparam logic [7:0] ES_RST      = 8'h38;
    localparam logic [7:0] SM_WMASK    = 8'h58;
    localparam logic [7:0] ES_WMASK    = 8'h87;
    localparam logic [7:0] SM_WMASK_LK = 8'h00;
    localparam logic [7:0] ES_WMASK_LK = 8'h00;

    localparam logic [1:0] SEL_SM  = 2'd0;
    localparam logic [1:0] SEL_ES  = 2'd1;
    localparam logic [1:0] SEL_XSZ = 2'd2;

    localparam logic [15:0] XSZ_QUERY = 16'hFFFF;
endpackage

// File: rtl/smram_ctl_regs.sv
// Control register file: SMRAM byte, extended byte, 16-bit size register.
// Applies lock-dependent write masks; lock forces the open bit clear.
// Assumes one write per cycle; read data is combinational.
module smram_ctl_regs
    import smram_pkg::*;
#(
    parameter int unsigned EXT_MB = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  sel,
    input  logic [15:0] wdata,
    output logic [7:0]  sm_q,
    output logic [7:0]  es_q,
    output logic [15:0] xsz_q,
    output logic [15:0] rdata
);
    localparam logic [15:0] XSZ_CFG = 16'(EXT_MB);
    localparam logic [15:0] XSZ_RST = (EXT_MB > 0) ? XSZ_QUERY : 16'h0000;

    logic       locked;
    logic [7:0] sm_mask;
    logic [7:0] es_mask;
    logic [7:0] sm_next;
    logic [7:0] es_next;

    assign locked = sm_q[SM_LOCK];

    // Pick write masks from the lock state
    always_comb begin
        sm_mask = locked ? SM_WMASK_LK : SM_WMASK;
        es_mask = locked ? ES_WMASK_LK : ES_WMASK;
    end

    // Merge write data under mask; lock clears open
    always_comb begin
        sm_next = (sm_q & ~sm_mask) | (wdata[7:0] & sm_mask);
        if (sm_next[SM_LOCK]) begin
            sm_next[SM_OPEN] = 1'b0;
        end
        es_next = (es_q & ~es_mask) | (wdata[7:0] & es_mask);
    end

    // SMRAM control byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sm_q <= SM_RST;
        end else if (we && sel == SEL_SM) begin
            sm_q <= sm_next;
        end
    end

    // Extended control byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q <= ES_RST;
        end else if (we && sel == SEL_ES) begin
            es_q <= es_next;
        end
    end

    generate
        if (EXT_MB > 0) begin : g_query
            // Size register with query replacement
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    xsz_q <= XSZ_RST;
                end else if (we && sel == SEL_XSZ) begin
                    xsz_q <= (wdata == XSZ_QUERY) ? XSZ_CFG : wdata;
                end
            end
        end else begin : g_plain
            // Size register without a configured extended size
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    xsz_q <= XSZ_RST;
                end else if (we && sel == SEL_XSZ) begin
                    xsz_q <= wdata;
                end
            end
        end
    endgenerate

    // Read-back multiplexer
    always_comb begin
        case (sel)
            SEL_SM:  rdata = {8'h00, sm_q};
            SEL_ES:  rdata = {8'h00, es_q};
            SEL_XSZ: rdata = xsz_q;
            default: rdata = 16'h0000;
        endcase
    end
endmodule

// File: rtl/smram_tseg_decode.sv
// Decodes the protected segment size from the extended byte and tests
// whether an address lies in [TOLUD - size, TOLUD).
// Assumes EXT_MB fits 12 bits and EXT_MB MB does not exceed TOLUD.
module smram_tseg_decode
    import smram_pkg::*;
#(
    parameter int unsigned    AW     = 32,
    parameter logic [AW-1:0]  TOLUD  = 32'h8000_0000,
    parameter int unsigned    EXT_MB = 16
) (
    input  logic [7:0]    es_q,
    input  logic [AW-1:0] addr,
    output logic          tseg_hit
);
    localparam logic [11:0] EXT_MB_W = 12'(EXT_MB);
    localparam logic [AW:0] TOP      = {1'b0, TOLUD};

    logic [11:0] seg_mb;
    logic [AW:0] seg_bytes;
    logic [AW:0] seg_base;
    logic [AW:0] addr_x;

    // Segment size in megabytes from the enable and size code
    always_comb begin
        case (es_q[ES_SZHI:ES_SZLO])
            2'b00:   seg_mb = 12'd1;
            2'b01:   seg_mb = 12'd2;
            2'b10:   seg_mb = 12'd8;
            default: seg_mb = EXT_MB_W;
        endcase
        if (!es_q[ES_TEN]) begin
            seg_mb = 12'd0;
        end
    end

    // Range test against the segment bounds
    always_comb begin
        seg_bytes = (AW+1)'(seg_mb) << 20;
        seg_base  = TOP - seg_bytes;
        addr_x    = {1'b0, addr};
        tseg_hit  = (seg_mb != 12'd0) && (addr_x >= seg_base) && (addr_x < TOP);
    end
endmodule

// File: rtl/smram_route_mux.sv
// Final routing decision: segment first, then SMM-only views, then the
// ordinary view of the legacy window and the high alias, then the
// low-memory split. Purely combinational.
module smram_route_mux
    import smram_pkg::*;
#(
    parameter int unsigned   AW        = 32,
    parameter logic [AW-1:0] TOLUD     = 32'h8000_0000,
    parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
    parameter logic [AW-1:0] HI_BASE   = 32'hFEDA_0000,
    parameter logic [AW-1:0] WIN_BYTES = 32'h0002_0000
) (
    input  logic [AW-1:0] addr,
    input  logic          smm,
    input  logic [7:0]    sm_q,
    input  logic [7:0]    es_q,
    input  logic          tseg_hit,
    output route_e        route
);
    localparam logic [AW:0] LOW_LO = {1'b0, LOW_BASE};
    localparam logic [AW:0] LOW_HI = {1'b0, LOW_BASE} + {1'b0, WIN_BYTES};
    localparam logic [AW:0] HI_LO  = {1'b0, HI_BASE};
    localparam logic [AW:0] HI_HI  = {1'b0, HI_BASE} + {1'b0, WIN_BYTES};

    logic [AW:0] addr_x;
    logic        low_hit;
    logic        hi_hit;
    logic        is_open;
    logic        g_en;
    logic        h_en;

    // Window hit detection
    always_comb begin
        addr_x  = {1'b0, addr};
        low_hit = (addr_x >= LOW_LO) && (addr_x < LOW_HI);
        hi_hit  = (addr_x >= HI_LO) && (addr_x < HI_HI);
        is_open = sm_q[SM_OPEN];
        g_en    = sm_q[SM_GEN];
        h_en    = es_q[ES_HEN];
    end

    // Priority routing
    always_comb begin
        if (tseg_hit) begin
            route = smm ? RT_DRAM : RT_HOLE;
        end else if (smm && g_en && ((low_hit && !h_en) || (hi_hit && h_en))) begin
            route = RT_DRAM;
        end else if (low_hit) begin
            route = (is_open && !h_en) ? RT_DRAM : RT_PCI;
        end else if (hi_hit) begin
            route = (is_open && h_en) ? RT_DRAM : RT_PCI;
        end else begin
            route = (addr < TOLUD) ? RT_DRAM : RT_PCI;
        end
    end
endmodule

// File: rtl/smram_router.sv
// Top: system-management memory visibility router. Holds the control
// registers and routes each access to DRAM, PCI or the hole.
// Assumes inputs are synchronous to clk; routing reflects registers.
module smram_router
    import smram_pkg::*;
#(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   DW        = 32,
    parameter logic [AW-1:0] TOLUD     = 32'h8000_0000,
    parameter int unsigned   EXT_MB    = 16,
    parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
    parameter logic [AW-1:0] HI_BASE   = 32'hFEDA_0000,
    parameter logic [AW-1:0] WIN_BYTES = 32'h0002_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [15:0]   cfg_wdata,
    output logic [15:0]   cfg_rdata,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_smm,
    input  logic          acc_wr,
    output logic [1:0]    acc_route,
    output logic [DW-1:0] hole_rdata,
    output logic          wr_drop
);
    logic [7:0]  sm_q;
    logic [7:0]  es_q;
    logic [15:0] xsz_q;
    logic        tseg_hit;
    route_e      route;

    smram_ctl_regs #(.EXT_MB(EXT_MB)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .sm_q  (sm_q),
        .es_q  (es_q),
        .xsz_q (xsz_q),
        .rdata (cfg_rdata)
    );

    smram_tseg_decode #(.AW(AW), .TOLUD(TOLUD), .EXT_MB(EXT_MB)) u_tseg (
        .es_q     (es_q),
        .addr     (acc_addr),
        .tseg_hit (tseg_hit)
    );

    smram_route_mux #(
        .AW(AW), .TOLUD(TOLUD), .LOW_BASE(LOW_BASE),
        .HI_BASE(HI_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_mux (
        .addr     (acc_addr),
        .smm      (acc_smm),
        .sm_q     (sm_q),
        .es_q     (es_q),
        .tseg_hit (tseg_hit),
        .route    (route)
    );

    // Drive the access-side outputs from the route
    always_comb begin
        acc_route  = route;
        hole_rdata = (route == RT_HOLE) ? {DW{1'b1}} : {DW{1'b0}};
        wr_drop    = acc_wr && (route == RT_HOLE);
    end
endmodule

// File: rtl/smram_router_chk.sv
// Property checker for smram_router, attached by bind below.
// Assumes inputs are stable around the rising clock edge.
module smram_router_chk
    import smram_pkg::*;
#(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   DW        = 32,
    parameter logic [AW-1:0] LOW_BASE  = 32'h000A_0000,
    parameter logic [AW-1:0] HI_BASE   = 32'hFEDA_0000,
    parameter logic [AW-1:0] WIN_BYTES = 32'h0002_0000
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] acc_addr,
    input logic          acc_smm,
    input logic          acc_wr,
    input logic [1:0]    acc_route,
    input logic [DW-1:0] hole_rdata,
    input logic          wr_drop,
    input logic [7:0]    sm_q,
    input logic [7:0]    es_q
);
    logic in_low;
    logic in_hi;

    // Independent window decode for the properties
    always_comb begin
        in_low = ({1'b0, acc_addr} >= {1'b0, LOW_BASE}) &&
                 ({1'b0, acc_addr} < ({1'b0, LOW_BASE} + {1'b0, WIN_BYTES}));
        in_hi  = ({1'b0, acc_addr} >= {1'b0, HI_BASE}) &&
                 ({1'b0, acc_addr} < ({1'b0, HI_BASE} + {1'b0, WIN_BYTES}));
    end

    a_r3_lock_clears_open: assert property (@(posedge clk) disable iff (!rst_n)
        sm_q[SM_LOCK] |-> !sm_q[SM_OPEN]);
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sm_q[SM_LOCK] |=> sm_q[SM_LOCK]);
    a_r3_ext_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        sm_q[SM_LOCK] |=> $stable(es_q));
    a_r8_smm_no_hole: assert property (@(posedge clk) disable iff (!rst_n)
        acc_smm |-> acc_route != RT_HOLE);
    a_r8_drop_needs_hole: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> (acc_wr && acc_route == RT_HOLE));
    a_r9_ones_only_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (hole_rdata != '0) |-> acc_route == RT_HOLE);
    a_r4_closed_low_pci: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_smm && !sm_q[SM_OPEN] && in_low) |-> acc_route == RT_PCI);
    a_r5_open_high_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_smm && sm_q[SM_OPEN] && es_q[ES_HEN] && in_hi) |-> acc_route == RT_DRAM);
endmodule

bind smram_router smram_router_chk #(
    .AW(AW), .DW(DW), .LOW_BASE(LOW_BASE), .HI_BASE(HI_BASE), .WIN_BYTES(WIN_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_addr   (acc_addr),
    .acc_smm    (acc_smm),
    .acc_wr     (acc_wr),
    .acc_route  (acc_route),
    .hole_rdata (hole_rdata),
    .wr_drop    (wr_drop),
    .sm_q       (sm_q),
    .es_q       (es_q)
);

// File: tb/tb_smram_router.sv
// Bench: behavioural reference model compared against every output on
// every cycle; inputs change on the falling edge.
module tb_smram_router;
    localparam longint TOP  = 64'h8000_0000;
    localparam int     XMB  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'h0;
    logic [15:0] cfg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_smm = 1'b0;
    logic        acc_wr = 1'b0;
    logic [1:0]  acc_route;
    logic [31:0] hole_rdata;
    logic        wr_drop;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [7:0]  m_sm;
    logic [7:0]  m_es;
    logic [15:0] m_xsz;

    smram_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .acc_wr(acc_wr), .acc_route(acc_route),
        .hole_rdata(hole_rdata), .wr_drop(wr_drop)
    );

    always #10 clk = ~clk;

    function automatic int seg_mb();
        if (!m_es[0]) return 0;
        case (m_es[2:1])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return XMB;
        endcase
    endfunction

    function automatic int exp_route(logic [31:0] a, bit smm);
        longint la = longint'(a);
        longint sz = longint'(seg_mb()) * 1048576;
        bit in_seg = (sz != 0) && (la >= TOP - sz) && (la < TOP);
        bit in_low = (la >= 64'hA0000) && (la < 64'hC0000);
        bit in_hi  = (la >= 64'hFEDA0000) && (la < 64'hFEDC0000);
        bit op = m_sm[6];
        bit g  = m_sm[3];
        bit h  = m_es[7];
        if (in_seg) return smm ? 0 : 2;
        if (smm && g && ((in_low && !h) || (in_hi && h))) return 0;
        if (in_low) return (op && !h) ? 0 : 1;
        if (in_hi) return (op && h) ? 0 : 1;
        return (la < TOP) ? 0 : 1;
    endfunction

    function automatic logic [15:0] exp_rd(logic [1:0] s);
        case (s)
            2'd0: return {8'h00, m_sm};
            2'd1: return {8'h00, m_es};
            2'd2: return m_xsz;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_reset();
        m_sm = 8'h02; m_es = 8'h38; m_xsz = 16'hFFFF;
    endtask

    task automatic model_write(logic [1:0] s, logic [15:0] d);
        logic [7:0] v;
        bit lk = m_sm[4];
        if (s == 2'd0 && !lk) begin
            v = (d[7:0] & 8'h58) | 8'h02;
            if (v[4]) v[6] = 1'b0;
            m_sm = v;
        end else if (s == 2'd1 && !lk) begin
            m_es = (d[7:0] & 8'h87) | 8'h38;
        end else if (s == 2'd2) begin
            m_xsz = (d == 16'hFFFF) ? 16'(XMB) : d;
        end
    endtask

    task automatic cmp(string tag, string what, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive, compare outputs of current state, then advance model
    task automatic cyc(bit we, logic [1:0] s, logic [15:0] d,
                       logic [31:0] a, bit smm, bit wr, string tag);
        int er;
        cfg_we = we; cfg_sel = s; cfg_wdata = d;
        acc_addr = a; acc_smm = smm; acc_wr = wr;
        #5;
        er = exp_route(a, smm);
        cmp(tag, "cfg_rdata", longint'(cfg_rdata), longint'(exp_rd(s)));
        cmp(tag, "acc_route", longint'(acc_route), longint'(er));
        cmp(tag, "hole_rdata", longint'(hole_rdata), (er == 2) ? 64'hFFFF_FFFF : 64'h0);
        cmp(tag, "wr_drop", longint'(wr_drop), longint'((er == 2) && wr));
        @(posedge clk);
        if (we) model_write(s, d);
        @(negedge clk);
    endtask

    task automatic do_reset();
        cfg_we = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic probe(logic [31:0] a, string tag);
        cyc(0, 2'd0, 16'h0, a, 0, 0, tag);
        cyc(0, 2'd1, 16'h0, a, 1, 0, tag);
        cyc(0, 2'd2, 16'h0, a, 0, 1, tag);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset values
        cyc(0, 2'd0, 16'h0, 32'h1000, 0, 0, "R1");
        cyc(0, 2'd1, 16'h0, 32'h1000, 0, 0, "R1");
        cyc(0, 2'd2, 16'h0, 32'h1000, 0, 0, "R1");
        cyc(0, 2'd3, 16'h0, 32'h1000, 0, 0, "R1");
        // R9 default split
        probe(32'h0000_1000, "R9");
        probe(32'h7FFF_FFFF, "R9");
        probe(32'hC000_0000, "R9");
        // R4 / R6 closed, global off
        probe(32'h000A_0000, "R4");
        probe(32'h000B_FFFF, "R6");
        probe(32'h000C_0000, "R9");
        // R2 masked write, open + global
        cyc(1, 2'd0, 16'hFFA7, 32'h000A_0000, 0, 0, "R2");
        cyc(0, 2'd0, 16'h0, 32'h000A_0000, 0, 0, "R2");
        cyc(1, 2'd0, 16'h0048, 32'h000A_0000, 0, 0, "R2");
        probe(32'h000A_8000, "R4");
        probe(32'hFEDA_0000, "R5");
        probe(32'hFEDB_FFFF, "R6");
        // high enable set
        cyc(1, 2'd1, 16'h7F80, 32'h0, 0, 0, "R2");
        probe(32'h000A_0000, "R4");
        probe(32'hFEDA_0000, "R5");
        probe(32'hFEDC_0000, "R9");
        probe(32'hFED9_FFFF, "R9");
        // closed, global on: SMM-only high view
        cyc(1, 2'd0, 16'h0008, 32'h0, 0, 0, "R6");
        probe(32'hFEDA_1234, "R6");
        probe(32'h000B_0000, "R6");
        cyc(1, 2'd1, 16'h0000, 32'h0, 0, 0, "R6");
        probe(32'h000B_0000, "R6");
        probe(32'hFEDA_1234, "R6");
        cyc(1, 2'd0, 16'h0000, 32'h0, 0, 0, "R6");
        probe(32'h000B_0000, "R6");
        // R7 / R8 segment sizes and edges
        for (int k = 0; k < 4; k++) begin
            longint sz;
            cyc(1, 2'd1, 16'((k << 1) | 1), 32'h0, 0, 0, "R7");
            sz = longint'(seg_mb()) * 1048576;
            probe(32'(TOP - sz - 1), "R7");
            probe(32'(TOP - sz), "R8");
            probe(32'(TOP - 1), "R8");
            probe(32'(TOP), "R9");
        end
        cyc(1, 2'd1, 16'h0006, 32'h0, 0, 0, "R7");
        probe(32'h7FFF_FFFF, "R7");
        // R10 size register
        cyc(1, 2'd2, 16'h1234, 32'h0, 0, 0, "R10");
        cyc(0, 2'd2, 16'h0, 32'h0, 0, 0, "R10");
        cyc(1, 2'd2, 16'hFFFF, 32'h0, 0, 0, "R10");
        cyc(0, 2'd2, 16'h0, 32'h0, 0, 0, "R10");
        // R3 lock with open in same write
        cyc(1, 2'd1, 16'h0081, 32'h0, 0, 0, "R3");
        cyc(1, 2'd0, 16'h0058, 32'h0, 0, 0, "R3");
        cyc(0, 2'd0, 16'h0, 32'h0, 0, 0, "R3");
        cyc(1, 2'd0, 16'h0048, 32'h0, 0, 0, "R3");
        cyc(0, 2'd0, 16'h0, 32'h0, 0, 0, "R3");
        cyc(1, 2'd1, 16'h0007, 32'h0, 0, 0, "R3");
        cyc(0, 2'd1, 16'h0, 32'h0, 0, 0, "R3");
        probe(32'h000A_0000, "R3");
        probe(32'hFEDA_0000, "R3");
        probe(32'h7FF0_0000, "R3");
        probe(32'h7FEF_FFFF, "R3");
        // reset releases lock
        do_reset();
        cyc(0, 2'd0, 16'h0, 32'h7FFF_FFFF, 0, 0, "R1");
        cyc(0, 2'd1, 16'h0, 32'h7FFF_FFFF, 0, 0, "R1");
        cyc(0, 2'd2, 16'h0, 32'h7FFF_FFFF, 0, 0, "R1");
        cyc(1, 2'd0, 16'h0040, 32'h0, 0, 0, "R2");
        probe(32'h000A_0000, "R4");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule